// File: doc/BRIEF.md
# Read Window Center Calculator

This block takes, for every byte lane, the first and the last passing point of a read-capture window, and computes the setting at the middle of that window as a coarse phase plus a fine delay. Each window edge is given as a phase and a delay. The block flattens each edge to a single linear position, takes the midpoint, and splits the midpoint back into a phase and a delay. It runs in one of two clock-ratio modes. In 1:1 mode the phase code is remapped before the arithmetic and a wider per-phase span is used. In 2:1 mode the phase is used as given, with the narrower span.

While it steps through the lanes it keeps the smallest center phase it has seen. When the last lane is done, it uses that minimum phase to pick a 3-bit adder from one of two packed words, one word per mode. It then reports the read-ready delay, which is the read sample delay plus that adder. A controller pulses `start` once the windows are known. The block handles one lane per cycle and pulses `done` when every result is valid.

Top module: `rwc_center_top`

## Requirements
- R1: Each window edge is flattened to a linear position, phase × span + delay, with span = 32 in 2:1 mode (`mode_2to1` = 1) and span = 48 in 1:1 mode. The linear center is (end − start)/2 + start, where the division by 2 truncates.
- R2: In 2:1 mode, a lane's center phase is the linear center divided by 32 (integer quotient) and its center delay is the remainder. Lane i uses bits [3i+2:3i] of each phase bus and bits [6i+5:6i] of each delay bus.
- R3: In 1:1 mode, an edge phase code of 4 is read as phase 1 before flattening, and the center phase and delay are the quotient and remainder by 48.
- R4: When a lane's linear end lies below its linear start, that lane's center becomes the start position, split by the same rule. `win_err` reads 1 after `done` if any lane of the run had this condition, and 0 otherwise.
- R5: `min_ph` equals the smallest center phase of the run just finished. It is set back to its maximum code when a run starts, so results from earlier runs do not carry over.
- R6: In 1:1 mode the adder is `adder_1to1[3m+2:3m]`, where m is the minimum phase (m = 0 to 3).
- R7: In 2:1 mode the adder is `adder_2to1[3m+2:3m]`, where m is the minimum phase (m = 0 to 7).
- R8: `ready_dly` equals `sample_dly` plus the selected adder, with no truncation.
- R9: A `start` seen while idle raises `busy` on the next cycle. `busy` stays high for NUM_LANES cycles. `done` is a single-cycle pulse that comes NUM_LANES+1 cycles after the `start` edge. A `start` seen while busy is ignored.
- R10: After reset, `busy`, `done`, `win_err`, `ready_dly` and all center outputs are 0, and `min_ph` holds its maximum code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a run (taken when idle) |
| mode_2to1 | input | 1 | 1 = 2:1 ratio, 0 = 1:1 ratio |
| win_s_ph | input | NUM_LANES*PHASE_W | Window start phase, per lane |
| win_s_dl | input | NUM_LANES*DELAY_W | Window start delay, per lane |
| win_e_ph | input | NUM_LANES*PHASE_W | Window end phase, per lane |
| win_e_dl | input | NUM_LANES*DELAY_W | Window end delay, per lane |
| sample_dly | input | SMPL_W | Read sample delay |
| adder_1to1 | input | 4*ADD_W | Packed adders used in 1:1 mode |
| adder_2to1 | input | 2**PHASE_W*ADD_W | Packed adders used in 2:1 mode |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse; results valid |
| win_err | output | 1 | Some lane had end below start |
| ctr_ph | output | NUM_LANES*PHASE_W | Center phase, per lane |
| ctr_dl | output | NUM_LANES*DELAY_W | Center delay, per lane |
| min_ph | output | PHASE_W | Minimum center phase |
| ready_dly | output | SMPL_W+1 | Sample delay plus selected adder |

## Verification
Six stimulus sets are used, each chosen to expose a particular fault:
- A 2:1 run whose windows have odd widths and cross phase boundaries. It separates a correct truncating midpoint from rounding, and a correct quotient/remainder split from an off-by-span one.
- 1:1 runs that put phase code 4 on both window edges. Only a design that remaps the code and uses the wider span gets these right.
- Runs with one or two inverted windows. They show the clamp-to-start rule, and they show that the error flag clears on the next run.
- Runs whose minimum phase falls at 0, in the middle, and at the top field. Each one reads a different adder field, and a high-phase run that follows a low-phase run shows that the minimum really restarts.

A directed test raises `start` again in the middle of a run, to confirm that the run length is unchanged.

// File: rtl/rwc_pkg.sv
// Package: shared types and fixed constants of the read window center calculator.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package rwc_pkg;

    // Run sequencer state
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } rwc_state_t;

    // In 1:1 mode this phase code stands for phase 1 during the arithmetic
    localparam int REMAP_FROM = 4;
    localparam int REMAP_TO   = 1;

    // Number of adder fields in the 1:1 word (phases 0..3)
    localparam int FIELDS_1TO1 = 4;

endpackage

// File: rtl/rwc_lane_math.sv
// Module: combinational center arithmetic for one lane.
// It flattens both window edges, takes the truncated midpoint (or the start
// when the window is inverted), and splits the result into a phase and a delay.
// Assumes: every delay input is below the span of the active mode, and in
// 1:1 mode the phase codes are 0..4.
module rwc_lane_math
    import rwc_pkg::*;
#(
    parameter int PHASE_W     = 3,
    parameter int DELAY_W     = 6,
    parameter int SPAN_NARROW = 32,
    parameter int SPAN_WIDE   = 48
) (
    input  logic               mode_2to1,
    input  logic [PHASE_W-1:0] s_ph,
    input  logic [DELAY_W-1:0] s_dl,
    input  logic [PHASE_W-1:0] e_ph,
    input  logic [DELAY_W-1:0] e_dl,
    output logic [PHASE_W-1:0] c_ph,
    output logic [DELAY_W-1:0] c_dl,
    output logic               inverted
);

    localparam int LIN_W = $clog2((2**PHASE_W) * SPAN_WIDE + 2**DELAY_W);

    logic [PHASE_W-1:0] ph_s_m, ph_e_m;
    logic [LIN_W-1:0]   span, lin_s, lin_e, mid, quo, rem;

    // Remap the phase codes of 1:1 mode
    always_comb begin
        ph_s_m = s_ph;
        ph_e_m = e_ph;
        if (!mode_2to1 && s_ph == PHASE_W'(REMAP_FROM)) ph_s_m = PHASE_W'(REMAP_TO);
        if (!mode_2to1 && e_ph == PHASE_W'(REMAP_FROM)) ph_e_m = PHASE_W'(REMAP_TO);
    end

    // Flatten both edges to linear positions
    always_comb begin
        span  = mode_2to1 ? LIN_W'(SPAN_NARROW) : LIN_W'(SPAN_WIDE);
        lin_s = LIN_W'(ph_s_m) * span + LIN_W'(s_dl);
        lin_e = LIN_W'(ph_e_m) * span + LIN_W'(e_dl);
    end

    // Midpoint, clamped to the start for an inverted window
    always_comb begin
        inverted = (lin_e < lin_s);
        mid      = inverted ? lin_s : (((lin_e - lin_s) >> 1) + lin_s);
    end

    // Split the midpoint by a constant divisor chosen by mode
    always_comb begin
        if (mode_2to1) begin
            quo = mid / LIN_W'(SPAN_NARROW);
            rem = mid % LIN_W'(SPAN_NARROW);
        end else begin
            quo = mid / LIN_W'(SPAN_WIDE);
            rem = mid % LIN_W'(SPAN_WIDE);
        end
        c_ph = PHASE_W'(quo);
        c_dl = DELAY_W'(rem);
    end

endmodule

// File: rtl/rwc_adder_sel.sv
// Module: picks the 3-bit ready-delay adder field chosen by the minimum phase.
// Assumes: PHASE_W >= 2. In 1:1 mode an index above 3 is clamped to
// field 3; the center arithmetic never produces such an index.
module rwc_adder_sel
    import rwc_pkg::*;
#(
    parameter int PHASE_W = 3,
    parameter int ADD_W   = 3
) (
    input  logic                              mode_2to1,
    input  logic [PHASE_W-1:0]                idx,
    input  logic [FIELDS_1TO1*ADD_W-1:0]      word_1to1,
    input  logic [(2**PHASE_W)*ADD_W-1:0]     word_2to1,
    output logic [ADD_W-1:0]                  add
);

    localparam int FIELDS_2TO1 = 2**PHASE_W;

    logic [ADD_W-1:0] fld_n [FIELDS_1TO1];
    logic [ADD_W-1:0] fld_w [FIELDS_2TO1];
    logic [1:0]       idx_n;

    // Unpack both packed words into field arrays
    for (genvar f = 0; f < FIELDS_1TO1; f++) begin : g_unpack_n
        assign fld_n[f] = word_1to1[f*ADD_W +: ADD_W];
    end
    for (genvar f = 0; f < FIELDS_2TO1; f++) begin : g_unpack_w
        assign fld_w[f] = word_2to1[f*ADD_W +: ADD_W];
    end

    // Select the field for the active mode
    always_comb begin
        idx_n = (idx > PHASE_W'(FIELDS_1TO1 - 1)) ? 2'd3 : idx[1:0];
        add   = mode_2to1 ? fld_w[idx] : fld_n[idx_n];
    end

endmodule

// File: rtl/rwc_center_top.sv
// Module: read window center calculator top.
// It steps over the lanes one per cycle after start, stores each lane's
// center, tracks the minimum center phase, and on the last lane registers
// the read-ready delay and pulses done.
// Assumes: inputs stay stable from the start pulse until done. NUM_LANES >= 2.
module rwc_center_top
    import rwc_pkg::*;
#(
    parameter int NUM_LANES   = 4,
    parameter int PHASE_W     = 3,
    parameter int DELAY_W     = 6,
    parameter int SPAN_NARROW = 32,
    parameter int SPAN_WIDE   = 48,
    parameter int SMPL_W      = 5,
    parameter int ADD_W       = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic                              mode_2to1,
    input  logic [NUM_LANES*PHASE_W-1:0]      win_s_ph,
    input  logic [NUM_LANES*DELAY_W-1:0]      win_s_dl,
    input  logic [NUM_LANES*PHASE_W-1:0]      win_e_ph,
    input  logic [NUM_LANES*DELAY_W-1:0]      win_e_dl,
    input  logic [SMPL_W-1:0]                 sample_dly,
    input  logic [4*ADD_W-1:0]                adder_1to1,
    input  logic [(2**PHASE_W)*ADD_W-1:0]     adder_2to1,
    output logic                              busy,
    output logic                              done,
    output logic                              win_err,
    output logic [NUM_LANES*PHASE_W-1:0]      ctr_ph,
    output logic [NUM_LANES*DELAY_W-1:0]      ctr_dl,
    output logic [PHASE_W-1:0]                min_ph,
    output logic [SMPL_W:0]                   ready_dly
);

    localparam int LANE_W = $clog2(NUM_LANES);
    localparam int RDY_W  = SMPL_W + 1;
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(NUM_LANES - 1);

    rwc_state_t         state_q;
    logic [LANE_W-1:0]  lane_q;
    logic [PHASE_W-1:0] min_q, min_nx, cur_ph;
    logic [DELAY_W-1:0] cur_dl;
    logic               cur_bad, accept, step, last;
    logic               done_q, err_q;
    logic [RDY_W-1:0]   ready_q;
    logic [ADD_W-1:0]   add_sel;
    logic [PHASE_W-1:0] ctr_ph_q [NUM_LANES];
    logic [DELAY_W-1:0] ctr_dl_q [NUM_LANES];

    // Sequencer decode
    assign accept = start && (state_q == ST_IDLE);
    assign step   = (state_q == ST_RUN);
    assign last   = step && (lane_q == LAST_LANE);

    // Arithmetic on the lane currently selected
    rwc_lane_math #(
        .PHASE_W     (PHASE_W),
        .DELAY_W     (DELAY_W),
        .SPAN_NARROW (SPAN_NARROW),
        .SPAN_WIDE   (SPAN_WIDE)
    ) u_math (
        .mode_2to1 (mode_2to1),
        .s_ph      (win_s_ph[lane_q*PHASE_W +: PHASE_W]),
        .s_dl      (win_s_dl[lane_q*DELAY_W +: DELAY_W]),
        .e_ph      (win_e_ph[lane_q*PHASE_W +: PHASE_W]),
        .e_dl      (win_e_dl[lane_q*DELAY_W +: DELAY_W]),
        .c_ph      (cur_ph),
        .c_dl      (cur_dl),
        .inverted  (cur_bad)
    );

    // Running minimum including the current lane
    assign min_nx = (cur_ph < min_q) ? cur_ph : min_q;

    // Adder chosen by the final minimum
    rwc_adder_sel #(
        .PHASE_W (PHASE_W),
        .ADD_W   (ADD_W)
    ) u_add (
        .mode_2to1 (mode_2to1),
        .idx       (min_nx),
        .word_1to1 (adder_1to1),
        .word_2to1 (adder_2to1),
        .add       (add_sel)
    );

    // Run sequencer: state, lane index and the done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lane_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                state_q <= ST_RUN;
                lane_q  <= '0;
            end else if (last) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
            end else if (step) begin
                lane_q <= lane_q + 1'b1;
            end
        end
    end

    // Minimum phase, error flag and read-ready delay
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_q   <= '1;
            err_q   <= 1'b0;
            ready_q <= '0;
        end else if (accept) begin
            min_q <= '1;
            err_q <= 1'b0;
        end else if (step) begin
            min_q <= min_nx;
            if (cur_bad) err_q <= 1'b1;
            if (last) ready_q <= RDY_W'(sample_dly) + RDY_W'(add_sel);
        end
    end

    // Per-lane result registers
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        // Capture this lane's center when it is processed
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctr_ph_q[i] <= '0;
                ctr_dl_q[i] <= '0;
            end else if (step && lane_q == LANE_W'(i)) begin
                ctr_ph_q[i] <= cur_ph;
                ctr_dl_q[i] <= cur_dl;
            end
        end
        assign ctr_ph[i*PHASE_W +: PHASE_W] = ctr_ph_q[i];
        assign ctr_dl[i*DELAY_W +: DELAY_W] = ctr_dl_q[i];

        // R5: the reported minimum never exceeds a lane's center
        assert_min_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
            done |-> (min_ph <= ctr_ph[i*PHASE_W +: PHASE_W]));
    end

    assign busy      = step;
    assign done      = done_q;
    assign win_err   = err_q;
    assign min_ph    = min_q;
    assign ready_dly = ready_q;

    // R2/R3: the delay remainder stays below the span of the active mode
    assert_rem_in_span_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (mode_2to1 ? (32'(cur_dl) < SPAN_NARROW) : (32'(cur_dl) < SPAN_WIDE)));

    // R9: done lasts a single cycle
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: an idle start always opens a run
    assert_start_runs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R9: every run that ends reports done
    assert_end_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R4: a new run begins with the error flag clear
    assert_err_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> !win_err);

    // R8: the ready delay is never below the sample delay it was built from
    assert_ready_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ready_dly >= RDY_W'($past(sample_dly))));

endmodule

// File: tb/test_rwc_center_top.sv
`timescale 1ns/1ps
// Bench: a vector table walked by one loop, then directed reset and busy tests.
module test_rwc_center_top;

    localparam int NL = 4;

    typedef struct packed {
        logic            m2;
        logic [3:0][2:0] sp;
        logic [3:0][5:0] sd;
        logic [3:0][2:0] ep;
        logic [3:0][5:0] ed;
        logic [4:0]      smp;
        logic [11:0]     wa;
        logic [23:0]     wb;
    } vec_t;

    // Lanes are listed lane3 first, lane0 last, in every concatenation
    localparam vec_t VECS [6] = '{
        '{1'b1, {3'd2,3'd3,3'd1,3'd0}, {6'd10,6'd0,6'd5,6'd0},
                {3'd4,3'd3,3'd2,3'd0}, {6'd4,6'd31,6'd7,6'd10},
                5'd9,  12'h000, 24'hFAC688},
        '{1'b0, {3'd0,3'd4,3'd0,3'd4}, {6'd0,6'd47,6'd10,6'd0},
                {3'd0,3'd2,3'd1,3'd4}, {6'd0,6'd0,6'd20,6'd40},
                5'd3,  12'hABC, 24'h000000},
        '{1'b1, {3'd5,3'd7,3'd6,3'd5}, {6'd31,6'd0,6'd0,6'd3},
                {3'd6,3'd7,3'd6,3'd7}, {6'd0,6'd2,6'd9,6'd31},
                5'd31, 12'h000, 24'h9F3E21},
        '{1'b0, {3'd3,3'd1,3'd0,3'd2}, {6'd1,6'd5,6'd5,6'd0},
                {3'd3,3'd3,3'd0,3'd1}, {6'd40,6'd0,6'd3,6'd0},
                5'd20, 12'h5A3, 24'h000000},
        '{1'b0, {3'd3,3'd3,3'd3,3'd3}, {6'd3,6'd2,6'd1,6'd0},
                {3'd3,3'd3,3'd3,3'd3}, {6'd47,6'd42,6'd41,6'd40},
                5'd0,  12'h7C5, 24'h123456},
        '{1'b1, {3'd2,3'd1,3'd7,3'd0}, {6'd0,6'd0,6'd0,6'd0},
                {3'd4,3'd1,3'd6,3'd0}, {6'd0,6'd20,6'd31,6'd1},
                5'd17, 12'h000, 24'hFFFFFF}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic mode_2to1 = 1'b0;
    logic [11:0] win_s_ph = '0, win_e_ph = '0;
    logic [23:0] win_s_dl = '0, win_e_dl = '0;
    logic [4:0]  sample_dly = '0;
    logic [11:0] adder_1to1 = '0;
    logic [23:0] adder_2to1 = '0;
    logic        busy, done, win_err;
    logic [11:0] ctr_ph;
    logic [23:0] ctr_dl;
    logic [2:0]  min_ph;
    logic [5:0]  ready_dly;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    rwc_center_top i_rwc_center_top (
        .clk (clk), .rst_n (rst_n), .start (start), .mode_2to1 (mode_2to1),
        .win_s_ph (win_s_ph), .win_s_dl (win_s_dl),
        .win_e_ph (win_e_ph), .win_e_dl (win_e_dl),
        .sample_dly (sample_dly), .adder_1to1 (adder_1to1), .adder_2to1 (adder_2to1),
        .busy (busy), .done (done), .win_err (win_err),
        .ctr_ph (ctr_ph), .ctr_dl (ctr_dl), .min_ph (min_ph), .ready_dly (ready_dly)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // R1/R3: linear position of one edge, from the requirement text
    function automatic int lin_pos(input bit m2, input int ph, input int dl);
        int p = (!m2 && ph == 4) ? 1 : ph;
        return p * (m2 ? 32 : 48) + dl;
    endfunction

    // Pulse start and count the cycles until done (R9)
    task automatic run_and_wait(input bit poke_mid, output int cyc);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cyc = 1;
        while (!done && cyc < 50) begin
            @(negedge clk);
            cyc++;
            if (poke_mid && cyc == 2) start = 1'b1;
            if (poke_mid && cyc == 3) start = 1'b0;
        end
    endtask

    task automatic apply_and_check(input vec_t v, input int k);
        int cyc, mn, err, span, s, e, c, add;
        mode_2to1 = v.m2; win_s_ph = v.sp; win_s_dl = v.sd;
        win_e_ph = v.ep; win_e_dl = v.ed; sample_dly = v.smp;
        adder_1to1 = v.wa; adder_2to1 = v.wb;
        run_and_wait(1'b0, cyc);
        check("R9", $sformatf("v%0d done latency", k), cyc, NL + 1);
        span = v.m2 ? 32 : 48;
        mn = 7; err = 0;
        for (int i = 0; i < NL; i++) begin
            s = lin_pos(v.m2, v.sp[i], v.sd[i]);
            e = lin_pos(v.m2, v.ep[i], v.ed[i]);
            if (e < s) begin c = s; err = 1; end   // R4 clamp
            else c = (e - s) / 2 + s;              // R1 midpoint
            if (c / span < mn) mn = c / span;
            check(v.m2 ? "R2" : "R3", $sformatf("v%0d lane%0d phase", k, i),
                  ctr_ph[i*3 +: 3], c / span);
            check(v.m2 ? "R2" : "R3", $sformatf("v%0d lane%0d delay", k, i),
                  ctr_dl[i*6 +: 6], c % span);
        end
        check("R4", $sformatf("v%0d error flag", k), win_err, err);
        check("R5", $sformatf("v%0d min phase", k), min_ph, mn);
        add = v.m2 ? int'(v.wb[mn*3 +: 3]) : int'(v.wa[mn*3 +: 3]);
        check(v.m2 ? "R7" : "R6", $sformatf("v%0d ready (R8)", k),
              ready_dly, v.smp + add);
    endtask

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        // R10: state right after reset
        check("R10", "busy", busy, 0);
        check("R10", "done", done, 0);
        check("R10", "win_err", win_err, 0);
        check("R10", "min_ph", min_ph, 7);
        check("R10", "ready_dly", ready_dly, 0);
        check("R10", "ctr_ph", ctr_ph, 0);
        check("R10", "ctr_dl", ctr_dl, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < 6; k++) apply_and_check(VECS[k], k);

        // R9: start raised during a run is ignored
        mode_2to1 = VECS[0].m2; win_s_ph = VECS[0].sp; win_s_dl = VECS[0].sd;
        win_e_ph = VECS[0].ep; win_e_dl = VECS[0].ed;
        run_and_wait(1'b1, cyc);
        check("R9", "latency with start poked mid-run", cyc, NL + 1);
        @(negedge clk);
        check("R9", "idle after done", busy, 0);
        check("R9", "done pulse width", done, 0);

        // R10: reset during a run returns to the reset state
        @(negedge clk) start = 1'b1;
        @(negedge clk) begin start = 1'b0; rst_n = 1'b0; end
        @(negedge clk);
        check("R10", "busy after mid-run reset", busy, 0);
        check("R10", "min_ph after mid-run reset", min_ph, 7);
        check("R10", "ctr_ph after mid-run reset", ctr_ph, 0);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule